// File: doc/BRIEF.md
# Cycle Timer With Watchdog and Shared Prescaler

This block pairs an 8-bit up-counter with a watchdog timer. The two share a single prescaler whose division ratio is set by a 3-bit code. The counter advances on instruction-cycle ticks or on a chosen edge of an external pin. It sets a sticky interrupt flag each time it wraps from all ones to zero. The watchdog advances on a free-running tick input that stands for its own slow oscillator. If software does not restart it in time, it emits a one-cycle reset pulse.

A mode register decides which side owns the prescaler. The side that does not own it runs undivided. The same 3-bit code gives a ratio of 1:2^(n+1) when the timer owns the prescaler and 1:2^n when the watchdog owns it. A host core writes the mode register and the counter through separate strobes. It restarts the watchdog with a kick strobe or a sleep strobe, and it reads the timeout and power-down status bits.

Top module: `cyc_timer_wdog`

## Requirements
- R1: After reset, count_q is 0, mode_q is 8'hFF (prescaler owned by the watchdog at code 7), ovf_flag and wdt_reset are 0, and timeout_n and powerdown_n are 1.
- R2: With mode bit 5 = 0 (internal source) and bit 3 = 0 (prescaler owned by the timer), the counter advances once per 2^(n+1) cyc_tick pulses, where n is mode bits 2:0.
- R3: With mode bit 3 = 1, the timer advances on every accepted source tick, and the watchdog advances once per 2^n wdt_tick pulses.
- R4: With mode bit 5 = 1, the counter source is pin_in after a two-flop synchronizer. Mode bit 4 = 0 counts low-to-high transitions and bit 4 = 1 counts high-to-low transitions. The other transition has no effect on count_q.
- R5: A counter increment from all ones to zero sets ovf_flag. The flag stays set until flag_clr is pulsed. A new overflow in the same cycle as flag_clr wins.
- R6: A cnt_we pulse loads cnt_wdata on the next edge. When the timer owns the prescaler, it also clears the prescaler count, and the next two cyc_tick pulses are not counted.
- R7: After 2^WDT_BITS watchdog increments without a restart, wdt_reset is high for exactly one cycle and timeout_n drops to 0.
- R8: A wdt_kick pulse restarts the watchdog count, sets timeout_n and powerdown_n to 1, and clears the prescaler when the watchdog owns it.
- R9: A sleep_req pulse restarts the watchdog count the same way, sets timeout_n to 1 and clears powerdown_n to 0.
- R10: A mode_we pulse clears the prescaler count. The side that does not own the prescaler counts its raw ticks at 1:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-cycle instruction-cycle tick enable |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| pin_in | input | 1 | Asynchronous external count pin |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_kick | input | 1 | Watchdog restart strobe |
| sleep_req | input | 1 | Sleep entry strobe; also restarts the watchdog |
| count_q | output | CNT_W | Current counter value |
| mode_q | output | 8 | Current mode register |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| wdt_reset | output | 1 | One-cycle watchdog timeout pulse |
| timeout_n | output | 1 | Low after a watchdog timeout |
| powerdown_n | output | 1 | Low after sleep entry |

## Verification
A prescaler count that is not cleared by a counter, mode or kick write shows at the ports as a count_q that advances, or a wdt_reset that fires, one or more ticks before the window computed from the ratio. A wrong mask shows as a count off by a factor of two within the first few hundred ticks of a ratio sweep. A hold window that is missing or too long shows in count_q immediately after the first two ticks following a counter write. A watchdog restart that leaves counter state behind shows as a reset pulse before 2^WDT_BITS times the ratio ticks.

// File: rtl/tmrw_pkg.sv
package tmrw_pkg;
   localparam int RATE_W = 3;
   localparam int MODE_W = 8;
   localparam int PSC_W  = 1 << RATE_W;

   typedef struct packed {
      logic [1:0]        spare;
      logic              src_pin;
      logic              edge_fall;
      logic              psc_wdt;
      logic [RATE_W-1:0] rate;
   } mode_t;
endpackage

// File: rtl/tw_pin_edge.sv
module tw_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_pin_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_raw};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
   import tmrw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick_in,
   input  logic [RATE_W-1:0] code,
   input  logic              to_wdt,
   output logic              tick_out
);
   localparam int SH_W = RATE_W + 1;

   logic [PSC_W-1:0] cnt;
   logic [SH_W-1:0]  shamt;
   logic [PSC_W:0]   span;
   logic [PSC_W:0]   span_m1;
   logic [PSC_W-1:0] mask;

   always_comb begin
      shamt   = to_wdt ? {1'b0, code} : ({1'b0, code} + SH_W'(1));
      span    = (PSC_W+1)'(1) << shamt;
      span_m1 = span - (PSC_W+1)'(1);
      mask    = span_m1[PSC_W-1:0];
   end

   assign tick_out = tick_in && ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (tick_in) cnt <= cnt + PSC_W'(1);
   end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
   parameter int WDT_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic kick,
   input  logic sleep,
   output logic bite,
   output logic to_n,
   output logic pd_n
);
   generate
      if (WDT_BITS < 2) begin : g_bad_bits
         $error("tw_watchdog: WDT_BITS must be at least 2");
      end
   endgenerate

   logic [WDT_BITS-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bite <= 1'b0;
         to_n <= 1'b1;
         pd_n <= 1'b1;
      end else if (kick || sleep) begin
         cnt  <= '0;
         bite <= 1'b0;
         to_n <= 1'b1;
         pd_n <= kick;
      end else if (inc) begin
         cnt  <= cnt + WDT_BITS'(1);
         bite <= (cnt == '1);
         if (cnt == '1) to_n <= 1'b0;
      end else begin
         bite <= 1'b0;
      end
   end

   assert_bite_drops_to_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bite |-> (!to_n && cnt == '0));

   assert_kick_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kick || sleep) |=> (cnt == '0 && to_n && !bite));
endmodule

// File: rtl/cyc_timer_wdog.sv
module cyc_timer_wdog
   import tmrw_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int WDT_BITS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              wdt_tick,
   input  logic              pin_in,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              flag_clr,
   input  logic              wdt_kick,
   input  logic              sleep_req,
   output logic [CNT_W-1:0]  count_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              ovf_flag,
   output logic              wdt_reset,
   output logic              timeout_n,
   output logic              powerdown_n
);
   localparam int HOLD_TICKS = 2;
   localparam int HOLD_W     = $clog2(HOLD_TICKS + 1);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cyc_timer_wdog: CNT_W must be at least 2");
      end
   endgenerate

   mode_t             mode_r;
   logic [HOLD_W-1:0] hold;
   logic              pin_rise, pin_fall, pin_evt;
   logic              src_tick, hold_on, tmr_src;
   logic              psc_in, psc_out, psc_clr;
   logic              tmr_inc, wdt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_r <= '1;
      else if (mode_we) mode_r <= mode_t'(mode_wdata);
   end
   assign mode_q = mode_r;

   tw_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .rise(pin_rise), .fall(pin_fall)
   );

   always_comb begin
      pin_evt  = mode_r.edge_fall ? pin_fall : pin_rise;
      src_tick = mode_r.src_pin ? pin_evt : cyc_tick;
      hold_on  = (hold != '0) && !mode_r.psc_wdt;
      tmr_src  = src_tick && !hold_on;
      psc_in   = mode_r.psc_wdt ? wdt_tick : tmr_src;
      psc_clr  = mode_we || (cnt_we && !mode_r.psc_wdt)
                 || ((wdt_kick || sleep_req) && mode_r.psc_wdt);
      tmr_inc  = mode_r.psc_wdt ? tmr_src : psc_out;
      wdt_inc  = mode_r.psc_wdt ? psc_out : wdt_tick;
   end

   tw_prescaler u_psc (
      .clk(clk), .rst_n(rst_n), .clr(psc_clr), .tick_in(psc_in),
      .code(mode_r.rate), .to_wdt(mode_r.psc_wdt), .tick_out(psc_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       hold <= '0;
      else if (cnt_we)                  hold <= HOLD_W'(HOLD_TICKS);
      else if (cyc_tick && hold != '0)  hold <= hold - HOLD_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (cnt_we)       count_q <= cnt_wdata;
         else if (tmr_inc) count_q <= count_q + CNT_W'(1);
         if (!cnt_we && tmr_inc && count_q == '1) ovf_flag <= 1'b1;
         else if (flag_clr)                       ovf_flag <= 1'b0;
      end
   end

   tw_watchdog #(.WDT_BITS(WDT_BITS)) u_wdt (
      .clk(clk), .rst_n(rst_n), .inc(wdt_inc), .kick(wdt_kick), .sleep(sleep_req),
      .bite(wdt_reset), .to_n(timeout_n), .pd_n(powerdown_n)
   );

   assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> count_q == $past(cnt_wdata));

   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we |=> (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1)));

   assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (count_q == '0 && $past(count_q) == '1));
endmodule

// File: tb/cyc_timer_wdog_tb_top.sv
module cyc_timer_wdog_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int WB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc_tick = 1'b0, wdt_tick = 1'b0, pin_in = 1'b0;
   logic          mode_we = 1'b0, cnt_we = 1'b0, flag_clr = 1'b0;
   logic          wdt_kick = 1'b0, sleep_req = 1'b0;
   logic [7:0]    mode_wdata = '0;
   logic [CW-1:0] cnt_wdata = '0;
   logic [CW-1:0] count_q;
   logic [7:0]    mode_q;
   logic          ovf_flag, wdt_reset, timeout_n, powerdown_n;

   int total = 0, bad = 0, bites = 0, cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cyc_timer_wdog #(.CNT_W(CW), .WDT_BITS(WB), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wdt_tick(wdt_tick),
      .pin_in(pin_in), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
      .wdt_kick(wdt_kick), .sleep_req(sleep_req), .count_q(count_q),
      .mode_q(mode_q), .ovf_flag(ovf_flag), .wdt_reset(wdt_reset),
      .timeout_n(timeout_n), .powerdown_n(powerdown_n)
   );

   always @(negedge clk) begin
      cycles++;
      if (rst_n && wdt_reset) bites++;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_mode(input logic [7:0] v);
      @(negedge clk); mode_we = 1'b1; mode_wdata = v;
      @(negedge clk); mode_we = 1'b0;
   endtask

   task automatic wr_cnt(input logic [CW-1:0] v);
      @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_we = 1'b0;
   endtask

   task automatic run_cyc(input int n);
      if (n > 0) begin
         @(negedge clk); cyc_tick = 1'b1;
         repeat (n) @(negedge clk);
         cyc_tick = 1'b0;
      end
   endtask

   task automatic run_wdt(input int n);
      if (n > 0) begin
         @(negedge clk); wdt_tick = 1'b1;
         repeat (n) @(negedge clk);
         wdt_tick = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic kick();
      @(negedge clk); wdt_kick = 1'b1;
      @(negedge clk); wdt_kick = 1'b0;
   endtask

   task automatic pin_level(input logic v);
      @(negedge clk); pin_in = v;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count_q, 0);
      chk("R1 mode", mode_q, 8'hFF);
      chk("R1 flag", ovf_flag, 0);
      chk("R1 wdt_reset", wdt_reset, 0);
      chk("R1 timeout_n", timeout_n, 1);
      chk("R1 powerdown_n", powerdown_n, 1);

      // R2 timer-owned ratio sweep, 2 held ticks then 3.x periods
      for (int n = 0; n < 8; n++) begin
         int r;
         r = 1 << (n + 1);
         wr_mode(8'(n));
         wr_cnt('0);
         run_cyc(2 + 3 * r + r - 1);
         chk($sformatf("R2 ratio code %0d", n), count_q, 3);
         chk("R2 mode readback", mode_q, n);
      end

      // R3 watchdog-owned prescaler: timer counts raw, no hold
      wr_mode(8'h08);
      wr_cnt(8'd10);
      run_cyc(5);
      chk("R3 timer 1:1", count_q, 15);

      // R6 hold and prescaler clear on counter write
      wr_mode(8'h00);
      wr_cnt('0);
      run_cyc(2);
      chk("R6 two ticks held", count_q, 0);
      run_cyc(2);
      chk("R6 first after hold", count_q, 1);
      wr_mode(8'h01);
      wr_cnt('0);
      run_cyc(5);
      chk("R6 partial ratio4", count_q, 0);
      wr_cnt(8'd5);
      run_cyc(5);
      chk("R6 psc cleared by write", count_q, 5);
      run_cyc(1);
      chk("R6 next step", count_q, 6);

      // R10 mode write clears prescaler
      wr_cnt('0);
      run_cyc(5);
      wr_mode(8'h01);
      run_cyc(3);
      chk("R10 after mode write", count_q, 0);
      run_cyc(1);
      chk("R10 completes period", count_q, 1);

      // R5 overflow flag
      wr_mode(8'h08);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      wr_cnt(8'hFE);
      run_cyc(1);
      chk("R5 at all ones", ovf_flag, 0);
      run_cyc(1);
      chk("R5 wrap count", count_q, 0);
      chk("R5 wrap sets flag", ovf_flag, 1);
      run_cyc(3);
      chk("R5 flag sticky", ovf_flag, 1);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk("R5 flag cleared", ovf_flag, 0);
      wr_cnt(8'hFF);
      @(negedge clk); cyc_tick = 1'b1; flag_clr = 1'b1;
      @(negedge clk); cyc_tick = 1'b0; flag_clr = 1'b0;
      chk("R5 set beats clear", ovf_flag, 1);

      // R4 pin source, rising edges, no prescaler
      cyc_tick = 1'b1;
      wr_mode(8'h28);
      wr_cnt('0);
      for (int i = 0; i < 5; i++) begin
         pin_level(1'b1);
         pin_level(1'b0);
      end
      chk("R4 rising edges", count_q, 5);
      // falling edges only
      wr_mode(8'h38);
      wr_cnt('0);
      pin_level(1'b1);
      chk("R4 rise ignored in fall mode", count_q, 0);
      pin_level(1'b0);
      chk("R4 fall counted", count_q, 1);
      // pin through timer-owned prescaler 1:4
      wr_mode(8'h21);
      wr_cnt('0);
      for (int i = 0; i < 8; i++) begin
         pin_level(1'b1);
         pin_level(1'b0);
      end
      chk("R4 pin prescaled", count_q, 2);
      cyc_tick = 1'b0;

      // R7 unprescaled watchdog timeout
      wr_mode(8'h00);
      kick();
      bites = 0;
      run_wdt((1 << WB) - 1);
      chk("R7 no early reset", bites, 0);
      chk("R7 timeout_n before", timeout_n, 1);
      run_wdt(1);
      chk("R7 one reset pulse", bites, 1);
      chk("R7 pulse width", wdt_reset, 0);
      chk("R7 timeout_n cleared", timeout_n, 0);

      // R8 kick restarts count
      kick();
      chk("R8 timeout_n set", timeout_n, 1);
      chk("R8 powerdown_n set", powerdown_n, 1);
      run_wdt(10);
      kick();
      bites = 0;
      run_wdt((1 << WB) - 1);
      chk("R8 restart window", bites, 0);
      run_wdt(1);
      chk("R8 fires after window", bites, 1);
      // R8 kick clears watchdog-owned prescaler
      wr_mode(8'h0A);
      kick();
      run_wdt(3);
      kick();
      bites = 0;
      run_wdt(4 * (1 << WB) - 1);
      chk("R8 psc cleared by kick", bites, 0);
      run_wdt(1);
      chk("R8 prescaled timeout", bites, 1);

      // R3 watchdog ratio sweep
      for (int n = 0; n < 8; n++) begin
         wr_mode(8'h08 | 8'(n));
         kick();
         bites = 0;
         run_wdt((1 << (WB + n)) - 1);
         chk($sformatf("R3 wdt code %0d early", n), bites, 0);
         run_wdt(1);
         chk($sformatf("R3 wdt code %0d fires", n), bites, 1);
      end

      // R9 sleep restarts and clears power-down bit
      wr_mode(8'h00);
      kick();
      run_wdt(10);
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
      chk("R9 powerdown_n cleared", powerdown_n, 0);
      chk("R9 timeout_n set", timeout_n, 1);
      bites = 0;
      run_wdt((1 << WB) - 1);
      chk("R9 restart window", bites, 0);
      run_wdt(1);
      chk("R9 timeout after sleep", bites, 1);
      chk("R9 powerdown_n held", powerdown_n, 0);
      kick();
      chk("R8 kick sets powerdown_n", powerdown_n, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule